// File: doc/BRIEF.md
# Valid-Qualified Serial-to-Parallel Receiver

This block is the receiving end of a narrow link between two devices. It takes a one-bit data line with a per-bit valid strobe. From that stream it rebuilds N-bit words, with the most significant bit arriving first. The stream carries no start marker. Word boundaries come only from counting the bits that arrive while valid is high. Words may arrive back to back, with valid held high across the boundary, or they may be separated by idle cycles.

If the valid strobe drops before a word is complete, the stream ended early. The partial word is thrown away and a one-cycle framing-error pulse is raised. A completed word appears on the parallel output together with a one-cycle ready pulse. It stays there until the next word completes.

The output side has no ready input and cannot apply back-pressure. The consumer must capture the word in the cycle the ready pulse is high, or read the held word before the next word completes. Likewise, the sender cannot be stalled. It must keep its word rate at or below one word per N cycles. N must be at least 2.

Top module: `s2p_rx`

## Requirements
- R1: While reset is asserted, and directly after it is released, the parallel output is all zeros and both pulse outputs are low.
- R2: The first valid bit of a word lands in output bit N-1 and the last lands in bit 0. With N=8, the serial bits 0,0,0,0,0,1,0,0 produce 8'h04.
- R3: word_rdy is high for exactly one cycle: the cycle that follows the clock edge on which the N-th valid bit of a word is taken. It is never high in the cycle after a valid-low cycle.
- R4: If valid stays high for k×N consecutive cycles, exactly k words are delivered, each built from its own N consecutive bits.
- R5: Idle cycles between complete words raise no framing error and no ready pulse, and they do not advance the bit count.
- R6: If valid is low on an edge after 1 to N-1 bits of a word have been taken, frame_err is high for exactly the next cycle. The partial word is discarded, and par_word keeps its previous value.
- R7: After a framing error, the next valid bit is taken as the first (most significant) bit of a new word.
- R8: par_word changes only in a cycle in which word_rdy is high.
- R9: word_rdy and frame_err are never high in the same cycle.
- R10: The value of ser_data while ser_valid is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_data | input | 1 | Serial data bit, sampled when ser_valid is high |
| ser_valid | input | 1 | Marks the cycles that carry a data bit |
| par_word | output | N | Last completed word |
| word_rdy | output | 1 | One-cycle pulse when par_word gets a new word |
| frame_err | output | 1 | One-cycle pulse when a partial word is discarded |

## Verification
Two kinds of work land on the same edge, and the bench provokes both.

The first is at a word boundary. When one word completes and the next bit follows at once, the edge that loads the output is also the edge after which the bit count restarts. The bench provokes this with long runs of back-to-back words.

The second follows an aborted word. A single idle cycle after a partial word is followed directly by a fresh word. The error pulse is then raised in the same cycle that the first bit of the new word is taken.

A behavioural model built on a queue of received bits predicts all three outputs. The bench compares them with the design on every clock. Directed words, idle cycles with the data line toggling, and random truncations are all judged this way.

// File: rtl/s2p_pkg.sv
package s2p_pkg;

  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_SHIFT = 2'd1,
    EV_DONE  = 2'd2,
    EV_ABORT = 2'd3
  } s2p_ev_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/s2p_frame_ctl.sv
module s2p_frame_ctl
  import s2p_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    valid,
  output s2p_ev_e ev
);
  localparam int unsigned CW = cnt_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_comb begin
    if (valid) begin
      ev = (cnt_q == LAST) ? EV_DONE : EV_SHIFT;
    end else begin
      ev = (cnt_q != '0) ? EV_ABORT : EV_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (ev)
        EV_SHIFT: cnt_q <= cnt_q + 1'b1;
        EV_DONE:  cnt_q <= '0;
        EV_ABORT: cnt_q <= '0;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/s2p_shift_reg.sv
module s2p_shift_reg
  import s2p_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  s2p_ev_e      ev,
  input  logic         din,
  output logic [N-1:0] assembled
);
  logic [N-1:0] sh_q;

  assign assembled = {sh_q[N-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      case (ev)
        EV_SHIFT: sh_q <= assembled;
        EV_DONE:  sh_q <= '0;
        EV_ABORT: sh_q <= '0;
        default:  sh_q <= sh_q;
      endcase
    end
  end
endmodule

// File: rtl/s2p_word_out.sv
module s2p_word_out
  import s2p_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  s2p_ev_e      ev,
  input  logic [N-1:0] assembled,
  output logic [N-1:0] word,
  output logic         rdy,
  output logic         err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      rdy  <= 1'b0;
      err  <= 1'b0;
    end else begin
      rdy <= (ev == EV_DONE);
      err <= (ev == EV_ABORT);
      if (ev == EV_DONE) begin
        word <= assembled;
      end
    end
  end
endmodule

// File: rtl/s2p_rx.sv
module s2p_rx
  import s2p_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_data,
  input  logic         ser_valid,
  output logic [N-1:0] par_word,
  output logic         word_rdy,
  output logic         frame_err
);
  s2p_ev_e      ev;
  logic [N-1:0] assembled;

  s2p_frame_ctl #(.N(N)) ctl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (ser_valid),
    .ev    (ev)
  );

  s2p_shift_reg #(.N(N)) shf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .din       (ser_data),
    .assembled (assembled)
  );

  s2p_word_out #(.N(N)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .assembled (assembled),
    .word      (par_word),
    .rdy       (word_rdy),
    .err       (frame_err)
  );
endmodule

// File: rtl/s2p_rx_chk.sv
module s2p_rx_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ser_valid,
  input logic [N-1:0] par_word,
  input logic         word_rdy,
  input logic         frame_err
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(word_rdy && frame_err)); // R9
  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) word_rdy |=> !word_rdy); // R3
  AST_RDY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) word_rdy |-> $past(ser_valid)); // R3
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_err |=> !frame_err); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) frame_err |-> !$past(ser_valid)); // R6
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !word_rdy |-> $stable(par_word)); // R8
endmodule

bind s2p_rx s2p_rx_chk #(.N(N)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_valid (ser_valid),
  .par_word  (par_word),
  .word_rdy  (word_rdy),
  .frame_err (frame_err)
);

// File: tb/s2p_rx_tb_top.sv
module s2p_rx_tb_top;
  localparam int unsigned N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_data = 1'b0;
  logic         ser_valid = 1'b0;
  logic [N-1:0] par_word;
  logic         word_rdy;
  logic         frame_err;

  int checks = 0;
  int errors = 0;
  int rdy_seen = 0;
  int err_seen = 0;

  bit           q[$];
  logic [N-1:0] m_word = '0;
  logic         m_rdy = 1'b0;
  logic         m_err = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  s2p_rx #(.N(N)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_data  (ser_data),
    .ser_valid (ser_valid),
    .par_word  (par_word),
    .word_rdy  (word_rdy),
    .frame_err (frame_err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_word = '0;
      m_rdy  = 1'b0;
      m_err  = 1'b0;
    end else begin
      m_rdy = 1'b0;
      m_err = 1'b0;
      if (ser_valid) begin
        q.push_back(ser_data);
        if (q.size() == N) begin
          for (int i = 0; i < N; i++) m_word[N-1-i] = q[i];
          m_rdy = 1'b1;
          q.delete();
        end
      end else if (q.size() != 0) begin
        m_err = 1'b1;
        q.delete();
      end
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 word", par_word, m_word);
    chk("R3 rdy", N'(word_rdy), N'(m_rdy));
    chk("R6 err", N'(frame_err), N'(m_err));
    chk("R9 exclusive", N'(word_rdy && frame_err), '0);
    if (word_rdy) rdy_seen++;
    if (frame_err) err_seen++;
  endtask

  task automatic step(input logic v, input logic d);
    @(negedge clk);
    compare();
    ser_valid = v;
    ser_data  = d;
  endtask

  task automatic send_bits(input logic [N-1:0] w, input int len);
    for (int i = 0; i < len; i++) step(1'b1, w[N-1-i]);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int r0;
    int e0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", par_word, '0);
    chk("R1 reset rdy", N'(word_rdy), '0);
    chk("R1 reset err", N'(frame_err), '0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    chk("R1 after release", {par_word[N-1:2], word_rdy, frame_err}, '0);

    // R2: pattern 00000100
    send_bits(8'h04, N);
    step(1'b0, 1'b1);
    chk("R2 msb first", par_word, 8'h04);

    // R10: data toggling while valid low
    e0 = err_seen;
    r0 = rdy_seen;
    for (int i = 0; i < 6; i++) step(1'b0, i[0]);
    chk("R10 word untouched", par_word, 8'h04);
    chk("R10 no pulses", N'((err_seen - e0) + (rdy_seen - r0)), '0);

    // R4: back-to-back words
    r0 = rdy_seen;
    send_bits(8'hA5, N);
    send_bits(8'h3C, N);
    send_bits(8'hF0, N);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R4 word count", N'(rdy_seen - r0), N'(3));
    chk("R4 last word", par_word, 8'hF0);

    // R5: idle gaps between complete words
    e0 = err_seen;
    send_bits(8'h81, N);
    repeat (3) step(1'b0, 1'b0);
    send_bits(8'h7E, N);
    repeat (2) step(1'b0, 1'b0);
    chk("R5 no error on gaps", N'(err_seen - e0), '0);
    chk("R5 word after gap", par_word, 8'h7E);

    // R6/R7: partial word, one idle cycle, fresh word at once
    e0 = err_seen;
    r0 = rdy_seen;
    send_bits(8'hFF, 3);
    send_bits(8'h5A, 1'b0 ? 0 : 0);
    step(1'b0, 1'b0);
    send_bits(8'h96, N);
    chk("R6 err pulse count", N'(err_seen - e0), N'(1));
    chk("R6 no ready for partial", N'(rdy_seen - r0), '0);
    chk("R6 word held", par_word, 8'h7E);
    step(1'b0, 1'b0);
    chk("R7 fresh word", par_word, 8'h96);

    // mixed random traffic with truncations
    for (int k = 0; k < 40; k++) begin
      logic [N-1:0] w;
      int len;
      w   = N'($urandom);
      len = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, N - 1)) : N;
      send_bits(w, len);
      for (int g = 0; g < int'($urandom_range(0, 2)); g++) step(1'b0, 1'($urandom));
    end
    repeat (3) step(1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule